// File: doc/BRIEF.md
# Serial Control Port Bridge

This block lets an external controller read and write 16-bit locations over a four-wire serial slave port: a serial clock, an active-low select, a data input and a data output. Every command has two 16-bit words. The first is an address word whose top bit gives the direction. The second is a data word, which the controller shifts in for a write and which the block shifts out for a read. The serial clock runs independently of the system clock. The block samples all three inputs into the system clock domain and works on edges that it detects there, so the system clock must be several times faster than the serial clock.

Addresses below the RAM limit belong to a DSP engine, which is not part of this block. The engine only polls for work now and then, so such accesses go through an address register, a data register and a level request. A write request is raised once the data word has arrived. A read request is raised as soon as the address word is complete, and the engine fills the data register when it acknowledges. The controller must leave a pause between the two words of a RAM read that is longer than the engine's polling interval. Addresses at or above the limit reach two board control registers directly: a card address and a transmit/receive bit offset.

Top module: `ctl_port_bridge`

## Requirements
- R1: After reset, `sdo_o`, both request outputs, `card_addr_o` and `bit_offset_o` are all 0.
- R2: A write command to address 0x1FFE loads the low CARD_W bits of the data word into `card_addr_o` once the 32nd serial bit has been sampled.
- R3: A write command to address 0x1FFC loads the low OFFS_W bits of the data word into `bit_offset_o`.
- R4: For a read, the data word is driven on `sdo_o` MSB first. The MSB is present before the 17th rising serial edge, and each following bit appears after the falling edge that follows a rising edge of the data word. Reading 0x1FFE or 0x1FFC returns the register zero-extended.
- R5: A write below 0x1400 puts the data word in `dsp_data_o` and the address in `dsp_addr_o`, and raises `dsp_irq_wr_o`. The request stays high until `dsp_ack_i` is high on a clock edge and is low in the cycle that follows.
- R6: A read below 0x1400 raises `dsp_irq_rd_o` once the address word is complete. On acknowledge, `dsp_rdata_i` is captured into `dsp_data_o`, the request drops in the next cycle, and the captured word is the one shifted out as the data word.
- R7: Bit 15 of the address word is the direction (1 = read, 0 = write) and bits 14:0 are the address. 0x13FF is a RAM address and 0x1400 is not.
- R8: Raising the select in the middle of a word aborts the command and clears the bit count, so the next command is framed from its first bit.
- R9: While a request is pending, a new RAM command is dropped. The address and data registers keep their values, and at most one request is high at any time.
- R10: `sdo_o` is 0 while the synchronised select is inactive.
- R11: A board address that is not mapped (0x1400 to 0x1FFF apart from the two registers) ignores writes and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller, idles low |
| scs_n_i | input | 1 | Active-low select; framing of a command |
| sdi_i | input | 1 | Serial data from the controller |
| sdo_o | output | 1 | Serial data to the controller |
| dsp_irq_rd_o | output | 1 | Level read request to the DSP engine |
| dsp_irq_wr_o | output | 1 | Level write request to the DSP engine |
| dsp_ack_i | input | 1 | One-cycle service acknowledge from the engine |
| dsp_addr_o | output | 15 | Address register seen by the engine |
| dsp_data_o | output | 16 | Data register seen by the engine |
| dsp_rdata_i | input | 16 | Word from the engine, captured on a read acknowledge |
| card_addr_o | output | 2 | Card address board register |
| bit_offset_o | output | 9 | TX/RX bit offset board register |

## Verification
The assertions assume that the engine raises `dsp_ack_i` only for one cycle while a request is pending. They also assume that the select pin is held inactive for the whole of reset, because the idle-output property looks two cycles back at the raw select pin. The stimulus pulses the acknowledge once per request, after the request has been seen, and keeps the select high through reset. Each serial half-period lasts six system clocks, so every serial edge is detected once, and the bench waits for the read request and its acknowledge before it clocks a RAM read's data word.

// File: rtl/ctlp_pkg.sv
// Shared constants and types for the serial control port bridge.
// Assumes 16-bit serial words whose top address bit carries the direction.
package ctlp_pkg;
    localparam int DEF_WORD_W    = 16;
    localparam int DEF_RAM_LIMIT = 'h1400;
    localparam int DEF_CARD_REG  = 'h1FFE;
    localparam int DEF_OFFS_REG  = 'h1FFC;

    // Kind of request outstanding towards the DSP engine.
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_RD   = 2'd1,
        REQ_WR   = 2'd2
    } req_e;
endpackage

// File: rtl/ctlp_sync.sv
// Multi-stage synchroniser for a small bundle of asynchronous inputs.
// Assumes each bit is sampled independently; each bit has its own reset value.
module ctlp_sync #(
    parameter int                WIDTH   = 1,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{RST_VAL}};
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctlp_shifter.sv
// Serial framing: detects serial clock edges in the system domain, assembles
// incoming words and shifts the outgoing word MSB first.
// Assumes the inputs are already synchronised and the system clock is at
// least four times faster than the serial clock.
module ctlp_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              sdi_s,
    input  logic              load_en,
    input  logic [WORD_W-1:0] load_data,
    output logic              addr_done_o,
    output logic              data_done_o,
    output logic [WORD_W-1:0] word_o,
    output logic              await_data_o,
    output logic              sdo_o
);
    localparam int CMD_BITS = 2 * WORD_W;
    localparam int CNT_W    = $clog2(CMD_BITS);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(WORD_W - 1);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(WORD_W);

    logic              sclk_q;
    logic              rise;
    logic              fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] in_sr;
    logic [WORD_W-1:0] out_sr;

    // Remember the previous synchronised serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_q & ~cs_n_s;
    assign fall = ~sclk_s & sclk_q & ~cs_n_s;

    // Count bits, shift data in and flag word completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt     <= '0;
            in_sr       <= '0;
            addr_done_o <= 1'b0;
            data_done_o <= 1'b0;
        end else begin
            addr_done_o <= 1'b0;
            data_done_o <= 1'b0;
            if (cs_n_s) begin
                bit_cnt <= '0;
            end else if (rise) begin
                in_sr       <= {in_sr[WORD_W-2:0], sdi_s};
                bit_cnt     <= (bit_cnt == CMD_LAST) ? '0 : bit_cnt + 1'b1;
                addr_done_o <= (bit_cnt == ADDR_LAST);
                data_done_o <= (bit_cnt == CMD_LAST);
            end
        end
    end

    // Load or shift the outgoing word; shifting starts after the first data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sr <= '0;
        end else if (load_en) begin
            out_sr <= load_data;
        end else if (fall && (bit_cnt > DATA_FIRST)) begin
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
        end
    end

    assign word_o       = in_sr;
    assign await_data_o = ~cs_n_s & (bit_cnt == DATA_FIRST);
    assign sdo_o        = ~cs_n_s & out_sr[WORD_W-1];
endmodule

// File: rtl/ctlp_dsp_req.sv
// Request handshake towards a polling DSP engine: holds the address and data
// registers and a level request until the engine acknowledges.
// Assumes the acknowledge is a one-cycle pulse given only while a request is
// pending. New commands are dropped while busy.
module ctlp_dsp_req #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_start,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] rdata_i,
    output logic              irq_rd_o,
    output logic              irq_wr_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [WORD_W-1:0] data_o,
    output logic              fill_o
);
    import ctlp_pkg::*;

    req_e state;

    // Track the outstanding request and the registers the engine sees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= REQ_NONE;
            addr_o <= '0;
            data_o <= '0;
            fill_o <= 1'b0;
        end else begin
            fill_o <= 1'b0;
            case (state)
                REQ_NONE: begin
                    if (rd_start) begin
                        state  <= REQ_RD;
                        addr_o <= addr_i;
                    end else if (wr_start) begin
                        state  <= REQ_WR;
                        addr_o <= addr_i;
                        data_o <= wdata_i;
                    end
                end
                REQ_RD: begin
                    if (ack_i) begin
                        state  <= REQ_NONE;
                        data_o <= rdata_i;
                        fill_o <= 1'b1;
                    end
                end
                REQ_WR: begin
                    if (ack_i) state <= REQ_NONE;
                end
                default: state <= REQ_NONE;
            endcase
        end
    end

    assign irq_rd_o = (state == REQ_RD);
    assign irq_wr_o = (state == REQ_WR);
endmodule

// File: rtl/ctlp_board_regs.sv
// Board control registers reached directly from the serial port: the card
// address and the TX/RX bit offset. Unmapped board addresses read as zero.
// Assumes a write strobe that lasts one cycle per completed command.
module ctlp_board_regs #(
    parameter int WORD_W    = 16,
    parameter int ADDR_W    = 15,
    parameter int CARD_W    = 2,
    parameter int OFFS_W    = 9,
    parameter int CARD_ADDR = 'h1FFE,
    parameter int OFFS_ADDR = 'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [CARD_W-1:0] card_o,
    output logic [OFFS_W-1:0] offs_o
);
    localparam logic [ADDR_W-1:0] CARD_A = ADDR_W'(CARD_ADDR);
    localparam logic [ADDR_W-1:0] OFFS_A = ADDR_W'(OFFS_ADDR);

    // Update whichever register a completed write command names.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            card_o <= '0;
            offs_o <= '0;
        end else if (wr_en) begin
            if (wr_addr == CARD_A) card_o <= wr_data[CARD_W-1:0];
            if (wr_addr == OFFS_A) offs_o <= wr_data[OFFS_W-1:0];
        end
    end

    // Return the addressed register zero-extended, or zero when unmapped.
    always_comb begin
        rd_data = '0;
        if (rd_addr == CARD_A)      rd_data[CARD_W-1:0] = card_o;
        else if (rd_addr == OFFS_A) rd_data[OFFS_W-1:0] = offs_o;
    end
endmodule

// File: rtl/ctl_port_bridge.sv
// Serial control port bridge top: synchronises the four-wire port, decodes
// the address word, and routes the command either to the DSP request
// handshake (below the RAM limit) or to the board registers.
// Assumes the controller waits for a RAM read to be serviced before it
// clocks that command's data word.
module ctl_port_bridge #(
    parameter int WORD_W      = ctlp_pkg::DEF_WORD_W,
    parameter int SYNC_STAGES = 2,
    parameter int CARD_W      = 2,
    parameter int OFFS_W      = 9,
    parameter int RAM_LIMIT   = ctlp_pkg::DEF_RAM_LIMIT,
    parameter int CARD_ADDR   = ctlp_pkg::DEF_CARD_REG,
    parameter int OFFS_ADDR   = ctlp_pkg::DEF_OFFS_REG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk_i,
    input  logic                scs_n_i,
    input  logic                sdi_i,
    output logic                sdo_o,
    output logic                dsp_irq_rd_o,
    output logic                dsp_irq_wr_o,
    input  logic                dsp_ack_i,
    output logic [WORD_W-2:0]   dsp_addr_o,
    output logic [WORD_W-1:0]   dsp_data_o,
    input  logic [WORD_W-1:0]   dsp_rdata_i,
    output logic [CARD_W-1:0]   card_addr_o,
    output logic [OFFS_W-1:0]   bit_offset_o
);
    localparam int ADDR_W = WORD_W - 1;
    localparam logic [ADDR_W-1:0] RAM_TOP = ADDR_W'(RAM_LIMIT);

    logic [2:0]        pins_s;
    logic              sclk_s;
    logic              cs_n_s;
    logic              sdi_s;
    logic              addr_done;
    logic              data_done;
    logic [WORD_W-1:0] word;
    logic              await_data;
    logic              load_en;
    logic [WORD_W-1:0] load_data;
    logic              fill;
    logic              rw_now;
    logic [ADDR_W-1:0] addr_now;
    logic              ram_now;
    logic              rw_q;
    logic              ram_q;
    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] board_rd;
    logic              rd_start;
    logic              wr_start;
    logic              board_wr;

    ctlp_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk_i, scs_n_i, sdi_i}),
        .q     (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_n_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    ctlp_shifter #(
        .WORD_W (WORD_W)
    ) u_shifter (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_s       (sclk_s),
        .cs_n_s       (cs_n_s),
        .sdi_s        (sdi_s),
        .load_en      (load_en),
        .load_data    (load_data),
        .addr_done_o  (addr_done),
        .data_done_o  (data_done),
        .word_o       (word),
        .await_data_o (await_data),
        .sdo_o        (sdo_o)
    );

    // Decode the address word as it completes.
    assign rw_now   = word[WORD_W-1];
    assign addr_now = word[ADDR_W-1:0];
    assign ram_now  = (addr_now < RAM_TOP);

    // Hold the decoded command for the data word phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q   <= 1'b0;
            ram_q  <= 1'b0;
            addr_q <= '0;
        end else if (addr_done) begin
            rw_q   <= rw_now;
            ram_q  <= ram_now;
            addr_q <= addr_now;
        end
    end

    assign rd_start = addr_done & rw_now & ram_now;
    assign wr_start = data_done & ~rw_q & ram_q;
    assign board_wr = data_done & ~rw_q & ~ram_q;

    ctlp_dsp_req #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_dsp_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_start (rd_start),
        .wr_start (wr_start),
        .addr_i   (addr_done ? addr_now : addr_q),
        .wdata_i  (word),
        .ack_i    (dsp_ack_i),
        .rdata_i  (dsp_rdata_i),
        .irq_rd_o (dsp_irq_rd_o),
        .irq_wr_o (dsp_irq_wr_o),
        .addr_o   (dsp_addr_o),
        .data_o   (dsp_data_o),
        .fill_o   (fill)
    );

    ctlp_board_regs #(
        .WORD_W    (WORD_W),
        .ADDR_W    (ADDR_W),
        .CARD_W    (CARD_W),
        .OFFS_W    (OFFS_W),
        .CARD_ADDR (CARD_ADDR),
        .OFFS_ADDR (OFFS_ADDR)
    ) u_board (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (board_wr),
        .wr_addr (addr_q),
        .wr_data (word),
        .rd_addr (addr_now),
        .rd_data (board_rd),
        .card_o  (card_addr_o),
        .offs_o  (bit_offset_o)
    );

    // Pick what the outgoing shifter loads: board data, zero, or a serviced read.
    always_comb begin
        load_en   = 1'b0;
        load_data = '0;
        if (addr_done) begin
            load_en   = 1'b1;
            load_data = (rw_now && !ram_now) ? board_rd : '0;
        end else if (fill && await_data) begin
            load_en   = 1'b1;
            load_data = dsp_data_o;
        end
    end
endmodule

// File: rtl/ctl_port_bridge_chk.sv
// Property checker for the serial control port bridge, bound to the top.
// Assumes the select pin is held inactive during reset.
module ctl_port_bridge_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scs_n_i,
    input logic              sdo_o,
    input logic              dsp_irq_rd_o,
    input logic              dsp_irq_wr_o,
    input logic              dsp_ack_i,
    input logic [WORD_W-2:0] dsp_addr_o,
    input logic [WORD_W-1:0] dsp_data_o
);
    // R5: a write request holds until acknowledged
    a_r5_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq_wr_o && !dsp_ack_i) |=> dsp_irq_wr_o);

    // R5: an acknowledged write request drops
    a_r5_wr_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq_wr_o && dsp_ack_i) |=> !dsp_irq_wr_o);

    // R5: the data register is steady while a write waits
    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq_wr_o && !dsp_ack_i) |=> $stable(dsp_data_o));

    // R6: a read request holds until acknowledged
    a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq_rd_o && !dsp_ack_i) |=> dsp_irq_rd_o);

    // R6: an acknowledged read request drops
    a_r6_rd_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_irq_rd_o && dsp_ack_i) |=> !dsp_irq_rd_o);

    // R9: never two requests at once
    a_r9_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsp_irq_rd_o, dsp_irq_wr_o}));

    // R9: the address register is steady while any request waits
    a_r9_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        ((dsp_irq_rd_o || dsp_irq_wr_o) && !dsp_ack_i) |=> $stable(dsp_addr_o));

    // R10: output is quiet once an inactive select has crossed the synchroniser
    a_r10_sdo_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(scs_n_i, 2) |-> !sdo_o);
endmodule

bind ctl_port_bridge ctl_port_bridge_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .scs_n_i      (scs_n_i),
    .sdo_o        (sdo_o),
    .dsp_irq_rd_o (dsp_irq_rd_o),
    .dsp_irq_wr_o (dsp_irq_wr_o),
    .dsp_ack_i    (dsp_ack_i),
    .dsp_addr_o   (dsp_addr_o),
    .dsp_data_o   (dsp_data_o)
);

// File: tb/ctl_port_bridge_tb_top.sv
// Self-checking bench: drives serial commands, plays the DSP engine and keeps
// a behavioural model of the board registers compared on every idle clock.
module ctl_port_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        scs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo_o;
    logic        dsp_irq_rd_o;
    logic        dsp_irq_wr_o;
    logic        dsp_ack = 1'b0;
    logic [14:0] dsp_addr_o;
    logic [15:0] dsp_data_o;
    logic [15:0] dsp_rdata = '0;
    logic [1:0]  card_addr_o;
    logic [8:0]  bit_offset_o;

    int n_checks = 0;
    int n_err    = 0;
    bit mon_en   = 1'b0;
    bit finished = 1'b0;
    int m_card   = 0;
    int m_offs   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_port_bridge dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_i       (sclk),
        .scs_n_i      (scs_n),
        .sdi_i        (sdi),
        .sdo_o        (sdo_o),
        .dsp_irq_rd_o (dsp_irq_rd_o),
        .dsp_irq_wr_o (dsp_irq_wr_o),
        .dsp_ack_i    (dsp_ack),
        .dsp_addr_o   (dsp_addr_o),
        .dsp_data_o   (dsp_data_o),
        .dsp_rdata_i  (dsp_rdata),
        .card_addr_o  (card_addr_o),
        .bit_offset_o (bit_offset_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Per-clock comparison of board registers against the model (R2, R3).
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R2", "card register vs model", 32'(card_addr_o), 32'(m_card));
            chk("R3", "offset register vs model", 32'(bit_offset_o), 32'(m_offs));
        end
    end

    task automatic shift_bit(input logic b, output logic so);
        sdi = b;
        repeat (HALF) @(negedge clk);
        so = sdo_o;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic xfer(input logic [15:0] aw, input logic [15:0] dw,
                        input bit serve, input logic [15:0] rdat,
                        output logic [15:0] got);
        logic so;
        int   t;
        mon_en = 1'b0;
        got = '0;
        scs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 15; i >= 0; i--) shift_bit(aw[i], so);
        if (serve) begin
            t = 0;
            while (!dsp_irq_rd_o && t < 100) begin
                @(negedge clk);
                t++;
            end
            chk("R6", "read request raised", 32'(dsp_irq_rd_o), 32'd1);
            chk("R7", "engine address", 32'(dsp_addr_o), 32'(aw[14:0]));
            repeat (4) @(negedge clk);
            dsp_rdata = rdat;
            dsp_ack = 1'b1;
            @(negedge clk);
            dsp_ack = 1'b0;
            repeat (4) @(negedge clk);
            chk("R6", "read request dropped", 32'(dsp_irq_rd_o), 32'd0);
        end
        for (int i = 15; i >= 0; i--) begin
            shift_bit(dw[i], so);
            got[i] = so;
        end
        repeat (HALF) @(negedge clk);
        scs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        dsp_ack = 1'b1;
        @(negedge clk);
        dsp_ack = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        logic so;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1", "sdo after reset", 32'(sdo_o), 32'd0);
        chk("R1", "read request after reset", 32'(dsp_irq_rd_o), 32'd0);
        chk("R1", "write request after reset", 32'(dsp_irq_wr_o), 32'd0);
        chk("R1", "card after reset", 32'(card_addr_o), 32'd0);
        chk("R1", "offset after reset", 32'(bit_offset_o), 32'd0);
        mon_en = 1'b1;
        repeat (5) @(negedge clk);

        // R2: card register write keeps the low bits only
        xfer(16'h1FFE, 16'hFFF6, 1'b0, '0, got);
        m_card = 2;
        mon_en = 1'b1;
        chk("R2", "card written", 32'(card_addr_o), 32'd2);

        // R4: card register read back MSB first
        xfer(16'h9FFE, 16'h0000, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R4", "card read data", 32'(got), 32'h0002);

        // R3: offset register write and read back
        xfer(16'h1FFC, 16'hFDA5, 1'b0, '0, got);
        m_offs = 'h1A5;
        mon_en = 1'b1;
        chk("R3", "offset written", 32'(bit_offset_o), 32'h1A5);
        xfer(16'h9FFC, 16'h0000, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R4", "offset read data", 32'(got), 32'h01A5);

        // R5: RAM write raises a held request
        xfer(16'h0123, 16'hBEEF, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R5", "write request raised", 32'(dsp_irq_wr_o), 32'd1);
        chk("R5", "write address", 32'(dsp_addr_o), 32'h0123);
        chk("R5", "write data register", 32'(dsp_data_o), 32'hBEEF);

        // R9: a second RAM write while pending is dropped
        xfer(16'h0200, 16'h1111, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R9", "address kept while busy", 32'(dsp_addr_o), 32'h0123);
        chk("R9", "data kept while busy", 32'(dsp_data_o), 32'hBEEF);
        chk("R9", "no read request while busy", 32'(dsp_irq_rd_o), 32'd0);
        ack_pulse();
        chk("R5", "write request cleared by ack", 32'(dsp_irq_wr_o), 32'd0);

        // R6, R7: RAM read at the top RAM address, serviced by the engine
        xfer(16'h93FF, 16'h0000, 1'b1, 16'h5A3C, got);
        mon_en = 1'b1;
        chk("R6", "read data shifted out", 32'(got), 32'h5A3C);
        chk("R6", "data register holds engine word", 32'(dsp_data_o), 32'h5A3C);
        chk("R10", "sdo quiet after select released", 32'(sdo_o), 32'd0);

        // R7, R11: 0x1400 is not RAM; reads zero and raises nothing
        xfer(16'h9400, 16'h0000, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R7", "no read request at 0x1400", 32'(dsp_irq_rd_o), 32'd0);
        chk("R11", "unmapped read returns zero", 32'(got), 32'h0000);
        xfer(16'h1400, 16'hFFFF, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R7", "no write request at 0x1400", 32'(dsp_irq_wr_o), 32'd0);
        xfer(16'h1FFD, 16'hFFFF, 1'b0, '0, got);
        mon_en = 1'b1;
        chk("R11", "card unchanged by unmapped write", 32'(card_addr_o), 32'd2);
        chk("R11", "offset unchanged by unmapped write", 32'(bit_offset_o), 32'h1A5);

        // R8: abort after 7 bits, then a clean write is framed correctly
        mon_en = 1'b0;
        scs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 7; i++) shift_bit(1'b1, so);
        scs_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
        mon_en = 1'b1;
        chk("R8", "abort leaves card unchanged", 32'(card_addr_o), 32'd2);
        chk("R8", "abort raises no request", 32'(dsp_irq_rd_o | dsp_irq_wr_o), 32'd0);
        xfer(16'h1FFE, 16'h0001, 1'b0, '0, got);
        m_card = 1;
        mon_en = 1'b1;
        chk("R8", "write framed after abort", 32'(card_addr_o), 32'd1);
        chk("R10", "sdo idle with select high", 32'(sdo_o), 32'd0);

        repeat (10) @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end
endmodule